// File: doc/BRIEF.md
# Cached Page Translation Unit

This block turns a logical address from a processor into a physical address for a system whose page table sits in ordinary memory as one contiguous array of frame numbers. Two context registers describe the running process: the table base and the highest legal page number. Software reloads both when it switches process. The logical address splits into a page number (upper bits) and an offset (lower bits). The page number is first checked against the limit. A page above the limit returns a fault and never touches memory.

A legal page number is then searched in a small fully associative cache of recent page-to-frame pairs. On a hit the frame comes straight from the cache. On a miss the block reads a single table entry at base plus page number through a one-outstanding read port. It installs the returned frame in the cache, replacing slots in round-robin order, and then answers. The physical address is the frame number joined above the unchanged offset. The data access that follows belongs to the requester.

Top module: `xlat_walker`

## Requirements
- R1: During and after reset, `req_ready` is 1 while `rsp_valid` and `mem_req` are 0. The cache is empty, the base register is 0 and the limit register is 0, so only page 0 is legal after reset.
- R2: A page number strictly greater than the limit register answers with `rsp_fault`=1 and `rsp_paddr`=0, with no memory read. A page number equal to the limit is legal.
- R3: Each miss issues exactly one `mem_req` pulse, one cycle wide, with `mem_addr` = base + page number, truncated to the address width (wraps).
- R4: A translated response carries `rsp_paddr` = {frame, offset}. The page number is `req_laddr[VPN_W+OFF_W-1:OFF_W]`, the offset is `req_laddr[OFF_W-1:0]`, and the frame is the low `PFN_W` bits of the table entry in the upper bits.
- R5: A page that is held in the cache answers with no memory read. `rsp_valid` is high in the second cycle after the accepting clock edge, that is, exactly one cycle after the lookup cycle.
- R6: A miss answers in the cycle right after the one in which `mem_rvalid` is sampled high. A `mem_rvalid` pulse arriving while no read is pending is ignored.
- R7: Fills go to cache slots in round-robin order starting at slot 0 after reset or flush. After `TLB_N`+1 distinct pages are filled, the first page is gone and the second is still held.
- R8: `tlb_flush` invalidates every cache slot at the next clock edge and returns the fill pointer to slot 0. If a flush and a fill coincide, the flush wins and the filled page is not kept.
- R9: Writing the base or limit register does not flush the cache. A cached page keeps its old frame after a base change. A new limit applies from the next request, ahead of any cache hit.
- R10: One request is handled at a time. `req_ready` is high only when idle, drops in the cycle after a request is accepted, and returns in the cycle after `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle, request accepted on this edge if valid |
| req_laddr | input | VPN_W+OFF_W | Logical address: page number above offset |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_fault | output | 1 | Page number above the limit |
| rsp_paddr | output | PFN_W+OFF_W | Physical address, 0 on fault |
| mem_req | output | 1 | One-cycle table entry read request |
| mem_addr | output | MA_W | Table entry address |
| mem_rvalid | input | 1 | Read data present |
| mem_rdata | input | PFN_W | Frame number read from the table |
| base_we | input | 1 | Load the table base register |
| base_wdata | input | MA_W | New table base |
| limit_we | input | 1 | Load the limit register |
| limit_wdata | input | VPN_W | New highest legal page number |
| tlb_flush | input | 1 | Invalidate all cache slots |

## Verification
A stale or duplicated cache slot shows up at the ports as a wrong frame in `rsp_paddr`, or as a memory read that should not happen (or one that is missing), on the very next request to that page. A wrong fill pointer stays hidden until the cache wraps, so eviction is checked only after `TLB_N`+1 distinct fills following a flush. A state machine that stalls or skips a state shows up as a response latency one or more cycles off the expected count, measured from either the accepting edge or the read-data edge.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    localparam int XL_VPN_W = 8;
    localparam int XL_OFF_W = 10;
    localparam int XL_PFN_W = 8;
    localparam int XL_MA_W  = 16;
    localparam int XL_TLB_N = 8;

    typedef enum logic [2:0] {
        XS_IDLE,
        XS_LOOKUP,
        XS_WALK_REQ,
        XS_WALK_WAIT,
        XS_RESPOND
    } xl_state_e;

    function automatic int unsigned xl_wrap_inc(input int unsigned v, input int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/xlat_tlb.sv
module xlat_tlb
    import xlat_pkg::*;
#(
    parameter int VPN_W = XL_VPN_W,
    parameter int PFN_W = XL_PFN_W,
    parameter int N     = XL_TLB_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
    } slot_t;

    slot_t            slot_q [N];
    logic [N-1:0]     vld_q;
    logic [IDX_W-1:0] ptr_q;
    logic [N-1:0]     match;

    generate
        for (genvar g = 0; g < N; g++) begin : g_cmp
            assign match[g] = vld_q[g] && (slot_q[g].vpn == look_vpn);
        end
    endgenerate

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < N; i++) begin
            if (match[i]) hit_pfn = hit_pfn | slot_q[i].pfn;
        end
    end

    assign hit = |match;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else if (fill_en) begin
            vld_q[ptr_q] <= 1'b1;
            ptr_q        <= IDX_W'(xl_wrap_inc(32'(ptr_q), N));
        end
    end

    always_ff @(posedge clk) begin
        if (fill_en) slot_q[ptr_q] <= '{vpn: fill_vpn, pfn: fill_pfn};
    end

    // R8
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (vld_q == '0));

    // R7
    single_match_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
    import xlat_pkg::*;
#(
    parameter int VPN_W = XL_VPN_W,
    parameter int PFN_W = XL_PFN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VPN_W-1:0] req_vpn,
    output logic             req_ready,
    input  logic [VPN_W-1:0] limit,
    output logic [VPN_W-1:0] vpn_q,
    input  logic             hit,
    input  logic [PFN_W-1:0] hit_pfn,
    output logic             mem_req,
    input  logic             mem_rvalid,
    input  logic [PFN_W-1:0] mem_pfn,
    output logic             fill_en,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [PFN_W-1:0] rsp_pfn
);
    xl_state_e        st_q, st_d;
    logic [PFN_W-1:0] pfn_q;
    logic             fault_q;
    logic             over;

    assign over = (vpn_q > limit);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            XS_IDLE:      if (req_valid) st_d = XS_LOOKUP;
            XS_LOOKUP:    st_d = (over || hit) ? XS_RESPOND : XS_WALK_REQ;
            XS_WALK_REQ:  st_d = XS_WALK_WAIT;
            XS_WALK_WAIT: if (mem_rvalid) st_d = XS_RESPOND;
            XS_RESPOND:   st_d = XS_IDLE;
            default:      st_d = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= XS_IDLE;
            vpn_q   <= '0;
            pfn_q   <= '0;
            fault_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (st_q == XS_IDLE && req_valid) vpn_q <= req_vpn;
            if (st_q == XS_LOOKUP) begin
                fault_q <= over;
                pfn_q   <= (over || !hit) ? '0 : hit_pfn;
            end
            if (st_q == XS_WALK_WAIT && mem_rvalid) begin
                fault_q <= 1'b0;
                pfn_q   <= mem_pfn;
            end
        end
    end

    assign req_ready = (st_q == XS_IDLE);
    assign mem_req   = (st_q == XS_WALK_REQ);
    assign fill_en   = (st_q == XS_WALK_WAIT) && mem_rvalid;
    assign rsp_valid = (st_q == XS_RESPOND);
    assign rsp_fault = fault_q;
    assign rsp_pfn   = pfn_q;

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    respond_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> req_ready);

    // R3
    single_read_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);

    // R6
    data_to_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        fill_en |=> (rsp_valid && !rsp_fault));

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xlat_pkg::*;
#(
    parameter int VPN_W = XL_VPN_W,
    parameter int OFF_W = XL_OFF_W,
    parameter int PFN_W = XL_PFN_W,
    parameter int MA_W  = XL_MA_W,
    parameter int TLB_N = XL_TLB_N
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VPN_W+OFF_W-1:0] req_laddr,
    output logic                   rsp_valid,
    output logic                   rsp_fault,
    output logic [PFN_W+OFF_W-1:0] rsp_paddr,
    output logic                   mem_req,
    output logic [MA_W-1:0]        mem_addr,
    input  logic                   mem_rvalid,
    input  logic [PFN_W-1:0]       mem_rdata,
    input  logic                   base_we,
    input  logic [MA_W-1:0]        base_wdata,
    input  logic                   limit_we,
    input  logic [VPN_W-1:0]       limit_wdata,
    input  logic                   tlb_flush
);
    logic [MA_W-1:0]  base_q;
    logic [VPN_W-1:0] limit_q;
    logic [OFF_W-1:0] off_q;
    logic [VPN_W-1:0] vpn_q;
    logic             hit;
    logic [PFN_W-1:0] hit_pfn;
    logic             fill_en;
    logic [PFN_W-1:0] rsp_pfn;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q  <= '0;
            limit_q <= '0;
            off_q   <= '0;
        end else begin
            if (base_we)  base_q  <= base_wdata;
            if (limit_we) limit_q <= limit_wdata;
            if (req_valid && req_ready) off_q <= req_laddr[OFF_W-1:0];
        end
    end

    xlat_ctrl #(.VPN_W(VPN_W), .PFN_W(PFN_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_vpn   (req_laddr[VPN_W+OFF_W-1:OFF_W]),
        .req_ready (req_ready),
        .limit     (limit_q),
        .vpn_q     (vpn_q),
        .hit       (hit),
        .hit_pfn   (hit_pfn),
        .mem_req   (mem_req),
        .mem_rvalid(mem_rvalid),
        .mem_pfn   (mem_rdata),
        .fill_en   (fill_en),
        .rsp_valid (rsp_valid),
        .rsp_fault (rsp_fault),
        .rsp_pfn   (rsp_pfn)
    );

    xlat_tlb #(.VPN_W(VPN_W), .PFN_W(PFN_W), .N(TLB_N)) u_tlb (
        .clk      (clk),
        .rst      (rst),
        .flush    (tlb_flush),
        .look_vpn (vpn_q),
        .hit      (hit),
        .hit_pfn  (hit_pfn),
        .fill_en  (fill_en),
        .fill_vpn (vpn_q),
        .fill_pfn (mem_rdata)
    );

    assign mem_addr  = base_q + MA_W'(vpn_q);
    assign rsp_paddr = rsp_fault ? '0 : {rsp_pfn, off_q};

    // R2
    no_read_on_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_fault) |-> $past(!mem_req, 1));

endmodule

// File: tb/xlat_walker_tb.sv
module xlat_walker_tb;

    localparam int VW = 8, OW = 10, PW = 8, AW = 16, NT = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1;
    logic req_valid = 1'b0, req_ready;
    logic [VW+OW-1:0] req_laddr = '0;
    logic rsp_valid, rsp_fault;
    logic [PW+OW-1:0] rsp_paddr;
    logic mem_req, mem_rvalid;
    logic [AW-1:0] mem_addr;
    logic [PW-1:0] mem_rdata;
    logic base_we = 1'b0, limit_we = 1'b0;
    logic [AW-1:0] base_wdata = '0;
    logic [VW-1:0] limit_wdata = '0;
    logic tlb_flush;

    logic model_rv = 1'b0, stray_rv = 1'b0;
    logic [PW-1:0] model_data = '0;
    logic fl_drv = 1'b0, fl_mem = 1'b0;
    assign mem_rvalid = model_rv | stray_rv;
    assign mem_rdata  = stray_rv ? 8'hEE : model_data;
    assign tlb_flush  = fl_drv | fl_mem;

    xlat_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_paddr(rsp_paddr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .base_we(base_we),
        .base_wdata(base_wdata), .limit_we(limit_we), .limit_wdata(limit_wdata),
        .tlb_flush(tlb_flush)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] pte(input logic [AW-1:0] a);
        int v;
        v = int'(a[7:0]) * 37 + int'(a[15:8]) * 5 + 11;
        return PW'(v & 255);
    endfunction

    // reference state built from the requirements
    logic [AW-1:0] m_base = '0;
    logic [VW-1:0] m_lim = '0;
    bit            m_v [NT];
    logic [VW-1:0] m_vpn [NT];
    logic [PW-1:0] m_pfn [NT];
    int            m_ptr = 0;

    task automatic model_clear();
        for (int i = 0; i < NT; i++) m_v[i] = 0;
        m_ptr = 0;
    endtask

    typedef struct {
        logic [PW+OW-1:0] pa;
        bit    f;
        bit    walk;
        int    acc;
        int    memc;
        string tag;
    } exp_t;
    exp_t q[$];

    int rv_cyc = 0, memreq_cnt = 0, mem_lat = 1;
    bit flush_on_fill = 0;
    logic [AW-1:0] exp_addr = '0;
    string cur_tag = "R3";
    int n_issued = 0, n_done = 0;

    // memory model
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && mem_req) begin
                memreq_cnt++;
                chk(mem_addr == exp_addr, cur_tag, "R3 walk address", mem_addr, exp_addr);
                repeat (mem_lat) @(negedge clk);
                model_rv   = 1'b1;
                model_data = pte(mem_addr);
                rv_cyc     = cyc;
                if (flush_on_fill) fl_mem = 1'b1;
                @(negedge clk);
                model_rv = 1'b0;
                fl_mem   = 1'b0;
            end
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (q.size() == 0) begin
                chk(0, "R10", "unexpected response", 1, 0);
            end else begin
                exp_t e;
                int   exp_c;
                e = q.pop_front();
                exp_c = e.walk ? rv_cyc + 1 : e.acc + 1;
                chk(rsp_fault == e.f, e.tag, "fault flag", rsp_fault, e.f);
                chk(rsp_paddr == e.pa, e.tag, "physical address", rsp_paddr, e.pa);
                chk(cyc == exp_c, e.tag, "response cycle", cyc, exp_c);
                chk((memreq_cnt - e.memc) == (e.walk ? 1 : 0), e.tag,
                    "memory reads", memreq_cnt - e.memc, e.walk ? 1 : 0);
            end
            n_done++;
        end
    end

    task automatic issue(input logic [VW-1:0] vpn, input logic [OW-1:0] off,
                         input string tag);
        exp_t e;
        bit   hit;
        logic [PW-1:0] pfn;
        hit = 0;
        pfn = '0;
        e.tag  = tag;
        e.walk = 0;
        e.f    = 0;
        if (vpn > m_lim) begin
            e.f  = 1;
            e.pa = '0;
        end else begin
            for (int i = 0; i < NT; i++)
                if (m_v[i] && m_vpn[i] == vpn) begin hit = 1; pfn = m_pfn[i]; end
            if (!hit) begin
                e.walk   = 1;
                exp_addr = m_base + AW'(vpn);
                pfn      = pte(exp_addr);
                if (flush_on_fill) model_clear();
                else begin
                    m_v[m_ptr] = 1; m_vpn[m_ptr] = vpn; m_pfn[m_ptr] = pfn;
                    m_ptr = (m_ptr + 1) % NT;
                end
            end
            e.pa = {pfn, off};
        end
        cur_tag = tag;
        e.acc  = cyc + 1;
        e.memc = memreq_cnt;
        q.push_back(e);
        n_issued++;
        req_valid = 1'b1;
        req_laddr = {vpn, off};
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
        wait (n_done == n_issued);
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready after response", req_ready, 1);
    endtask

    task automatic set_base(input logic [AW-1:0] v);
        base_we = 1'b1; base_wdata = v;
        @(negedge clk);
        base_we = 1'b0;
        m_base = v;
    endtask

    task automatic set_lim(input logic [VW-1:0] v);
        limit_we = 1'b1; limit_wdata = v;
        @(negedge clk);
        limit_we = 1'b0;
        m_lim = v;
    endtask

    task automatic do_flush();
        fl_drv = 1'b1;
        @(negedge clk);
        fl_drv = 1'b0;
        model_clear();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "R10", "watchdog expired", cyc, 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid in reset", rsp_valid, 0);
        chk(mem_req == 1'b0, "R1", "mem_req in reset", mem_req, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);

        // R1: reset limit 0, reset base 0
        issue(8'd1, 10'h001, "R1");
        issue(8'd0, 10'h3FF, "R1");

        set_base(16'h0100);
        set_lim(8'h20);

        // R6: stray read data while idle
        stray_rv = 1'b1;
        @(negedge clk);
        stray_rv = 1'b0;
        chk(rsp_valid == 1'b0, "R6", "stray data response", rsp_valid, 0);
        chk(req_ready == 1'b1, "R6", "stray data state", req_ready, 1);

        issue(8'd3, 10'h155, "R4");
        issue(8'd3, 10'h2AA, "R5");
        mem_lat = 3;
        issue(8'h20, 10'h012, "R2");
        issue(8'h21, 10'h012, "R2");
        issue(8'hFF, 10'h3FF, "R2");
        mem_lat = 2;
        issue(8'd7, 10'h0C3, "R6");

        // R9: context writes do not flush
        set_base(16'h0200);
        issue(8'd3, 10'h001, "R9");
        set_lim(8'd2);
        issue(8'd3, 10'h001, "R9");
        set_lim(8'h40);

        // R8: flush then refetch under new base
        do_flush();
        issue(8'd3, 10'h001, "R8");

        // R7: round robin eviction
        mem_lat = 1;
        do_flush();
        for (int p = 10; p < 10 + NT + 1; p++) issue(VW'(p), 10'h020, "R7");
        issue(8'd12, 10'h021, "R7");
        issue(8'd11, 10'h022, "R7");
        issue(8'd10, 10'h023, "R7");

        // R8: flush coinciding with fill
        flush_on_fill = 1;
        issue(8'd5, 10'h100, "R8");
        flush_on_fill = 0;
        issue(8'd5, 10'h101, "R8");
        issue(8'd12, 10'h102, "R8");

        // R3: table address wraps
        set_base(16'hFFF0);
        issue(8'h20, 10'h0AB, "R3");

        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R10", "pending expectations", q.size(), 0);
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule